// File: doc/BRIEF.md
# Multi-Channel Interval Timer with Aggregated Interrupt

This block holds a small set of independent 30-bit hardware timers behind a synchronous register bus and folds their expiry events, together with an external watchdog warning, into a single level interrupt line for a parent interrupt controller. Each timer counts up once per clock while running. It raises its own pending bit when the count reaches a programmed limit, and then either reloads to zero and keeps running or stops itself.

Software unmasks individual timer sources in a shared enable register and acknowledges events by writing ones to a shared pending register. The watchdog warning has a pending bit placed directly above the timer bits. That bit cannot be masked, so a warning always reaches the parent line. A build-time parameter picks one of two register arrangements. The compact one has three timers with byte-wide enable and pending registers packed into byte lanes 2 and 3 of word 0. The wide one has four timers with word-wide enable and pending registers.

Top module: `multi_timer_irq`

## Requirements
- R1: `WIDE_LAYOUT`=0 gives 3 timers, with enable in byte lane 2 (bits 23:16) of word 0, pending in byte lane 3 (bits 31:24) of word 0, control words 1..3 and count words 4..6. `WIDE_LAYOUT`=1 gives 4 timers, with enable in word 0, pending in word 1, control words 2..5 and count words 6..9. A register byte is written only when its `bus_be` bit is set.
- R2: A control word holds run at bit 31, reload at bit 30 and the 30-bit limit at bits 29:0. It reads back as written.
- R3: A count word holds a 30-bit count. Bits 31:30 read as zero and are discarded on write.
- R4: A running timer's count rises by one each clock unless it matches the limit. A stopped timer's count holds.
- R5: When a running timer's count equals its limit, its pending bit n is set at that clock edge. With reload=1 the count returns to zero and the timer keeps running, giving a period of limit+1 clocks.
- R6: With reload=0, a match clears the run bit and the count stays at the limit.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a hardware set and a clear hit the same bit in the same cycle, the bit stays set.
- R8: A high `wdog_warn` at a clock edge sets pending bit NT, where NT is the timer count. The enable register has no bit for the watchdog: its bits at NT and above read zero.
- R9: `irq_o` is registered and low after reset. It goes high one clock after any pending timer bit whose enable bit is set, or after the pending watchdog bit, and it is low one clock after neither holds.
- R10: Words outside the map read as zero, and writes to them change nothing.
- R11: `bus_rdata` updates on the clock edge at which `bus_rd` is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | WORD_AW | Word address |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdog_warn | input | 1 | Watchdog warning, level sampled each clock |
| irq_o | output | 1 | Aggregated interrupt to the parent controller |

## Verification
The assertions assume that strobes and the watchdog input are synchronous to `clk` and stable around its rising edge. They also assume that a word address and its byte enables are only meaningful while a strobe is high. The bench drives every input at the falling edge and keeps read and write strobes to single-cycle pulses, so each access lands on exactly one rising edge. Random limits are kept small and run lengths short, which lets the one-shot, periodic and masked cases reach a match many times. Before each trial all timers are stopped and the pending bits are cleared, so the trials start from a known state and do not interfere.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W = 30;

    // Control word: run at bit 31, reload at bit 30, limit below.
    typedef struct packed {
        logic             run;
        logic             reload;
        logic [CNT_W-1:0] limit;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             cnt_we,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    output tmr_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     hit;

    always_comb begin
        s_d = s_q;
        hit = s_q.ctrl.run && (s_q.cnt == s_q.ctrl.limit);
        if (s_q.ctrl.run) begin
            if (hit) begin
                if (s_q.ctrl.reload) s_d.cnt = '0;
                else                 s_d.ctrl.run = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        // Software writes override the hardware update, per byte lane.
        if (ctrl_we) begin
            for (int i = 0; i < 32; i++)
                if (be[i/8]) s_d.ctrl[i] = wdata[i];
        end
        if (cnt_we) begin
            for (int i = 0; i < CNT_W; i++)
                if (be[i/8]) s_d.cnt[i] = wdata[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o = s_q.ctrl;
    assign cnt_o  = s_q.cnt;
    assign hit_o  = hit;

    // R4: running without a match advances by exactly one.
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.run && !hit && !cnt_we) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R4: a stopped timer keeps its count.
    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.run && !cnt_we) |=> $stable(s_q.cnt));

    // R5: a periodic match restarts from zero and keeps running.
    a_r5_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && s_q.ctrl.reload && !cnt_we && !ctrl_we) |=> (s_q.cnt == '0 && s_q.ctrl.run));

    // R6: a one-shot match stops the timer at its limit.
    a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !s_q.ctrl.reload && !ctrl_we && !cnt_we) |=> (!s_q.ctrl.run && $stable(s_q.cnt)));
endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg #(
    parameter int NT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] hit_i,
    input  logic          wdog_i,
    input  logic [NT-1:0] en_wval,
    input  logic [NT-1:0] en_wmask,
    input  logic [NT:0]   st_wval,
    input  logic [NT:0]   st_wmask,
    output logic [NT-1:0] en_o,
    output logic [NT:0]   st_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [NT-1:0] en;
        logic [NT:0]   st;
        logic          irq;
    } agg_st_t;

    agg_st_t     s_d, s_q;
    logic [NT:0] set_vec;
    logic [NT:0] clr_vec;

    always_comb begin
        s_d     = s_q;
        set_vec = {wdog_i, hit_i};
        clr_vec = st_wval & st_wmask;
        s_d.en  = (s_q.en & ~en_wmask) | (en_wval & en_wmask);
        // A set in the same cycle as a clear keeps the bit.
        s_d.st  = (s_q.st & ~clr_vec) | set_vec;
        // Watchdog bit is always unmasked.
        s_d.irq = |(s_q.st & {1'b1, s_q.en});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o  = s_q.en;
    assign st_o  = s_q.st;
    assign irq_o = s_q.irq;

    // R7: every source raised this cycle is pending next cycle.
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((s_q.st & $past(set_vec)) == $past(set_vec)));

    // R7: cleared bits without a simultaneous set are gone.
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & set_vec) == '0 && |clr_vec) |=> ((s_q.st & $past(clr_vec)) == '0));

    // R8: a pending watchdog bit reaches the line regardless of the enables.
    a_r8_wdog_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st[NT] |=> irq_o);

    // R9: nothing pending and unmasked leaves the line low.
    a_r9_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st & {1'b1, s_q.en}) == '0) |=> !irq_o);
endmodule

// File: rtl/tmr_bus.sv
module tmr_bus import tmr_pkg::*; #(
    parameter bit WIDE = 1'b0,
    parameter int NT   = 3,
    parameter int AW   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [AW-1:0]             bus_word,
    input  logic [3:0]                bus_be,
    input  logic [31:0]               bus_wdata,
    input  logic [NT-1:0]             en_i,
    input  logic [NT:0]               st_i,
    input  tmr_ctrl_t [NT-1:0]        ctrl_i,
    input  logic [NT-1:0][CNT_W-1:0]  cnt_i,
    output logic [NT-1:0]             ctrl_we,
    output logic [NT-1:0]             cnt_we,
    output logic [NT-1:0]             en_wval,
    output logic [NT-1:0]             en_wmask,
    output logic [NT:0]               st_wval,
    output logic [NT:0]               st_wmask,
    output logic [31:0]               bus_rdata
);
    localparam int EN_WORD   = 0;
    localparam int ST_WORD   = WIDE ? 1 : 0;
    localparam int EN_LANE   = WIDE ? 0 : 2;
    localparam int ST_LANE   = WIDE ? 0 : 3;
    localparam int CTRL_WORD = WIDE ? 2 : 1;
    localparam int CNT_WORD  = CTRL_WORD + NT;

    typedef struct packed {
        logic [31:0] rdata;
    } bus_st_t;

    bus_st_t     s_d, s_q;
    logic [31:0] rd_mux;
    logic        hit_en, hit_st;

    assign hit_en = (bus_word == AW'(EN_WORD));
    assign hit_st = (bus_word == AW'(ST_WORD));

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            en_wval[i]  = bus_wdata[8*EN_LANE + i];
            en_wmask[i] = bus_wr && hit_en && bus_be[(8*EN_LANE + i)/8];
        end
        for (int i = 0; i <= NT; i++) begin
            st_wval[i]  = bus_wdata[8*ST_LANE + i];
            st_wmask[i] = bus_wr && hit_st && bus_be[(8*ST_LANE + i)/8];
        end
    end

    for (genvar n = 0; n < NT; n++) begin : g_dec
        assign ctrl_we[n] = bus_wr && (bus_word == AW'(CTRL_WORD + n));
        assign cnt_we[n]  = bus_wr && (bus_word == AW'(CNT_WORD + n));
    end

    always_comb begin
        rd_mux = '0;
        if (hit_en) rd_mux = rd_mux | (32'(en_i) << (8*EN_LANE));
        if (hit_st) rd_mux = rd_mux | (32'(st_i) << (8*ST_LANE));
        for (int n = 0; n < NT; n++) begin
            if (bus_word == AW'(CTRL_WORD + n)) rd_mux = rd_mux | 32'(ctrl_i[n]);
            if (bus_word == AW'(CNT_WORD + n))  rd_mux = rd_mux | 32'(cnt_i[n]);
        end
    end

    always_comb begin
        s_d = s_q;
        if (bus_rd) s_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;

    // R11: read data moves only on a read strobe.
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R10: one write reaches at most one timer register.
    a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_we, cnt_we}));
endmodule

// File: rtl/multi_timer_irq.sv
module multi_timer_irq import tmr_pkg::*; #(
    parameter bit WIDE_LAYOUT = 1'b0,
    parameter int WORD_AW     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [WORD_AW-1:0] bus_word,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               wdog_warn,
    output logic               irq_o
);
    localparam int NT = WIDE_LAYOUT ? 4 : 3;

    tmr_ctrl_t [NT-1:0]       ctrl;
    logic [NT-1:0][CNT_W-1:0] cnt;
    logic [NT-1:0]            hit;
    logic [NT-1:0]            ctrl_we, cnt_we;
    logic [NT-1:0]            en_wval, en_wmask, en_q;
    logic [NT:0]              st_wval, st_wmask, st_q;

    tmr_bus #(.WIDE(WIDE_LAYOUT), .NT(NT), .AW(WORD_AW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_word  (bus_word),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .en_i      (en_q),
        .st_i      (st_q),
        .ctrl_i    (ctrl),
        .cnt_i     (cnt),
        .ctrl_we   (ctrl_we),
        .cnt_we    (cnt_we),
        .en_wval   (en_wval),
        .en_wmask  (en_wmask),
        .st_wval   (st_wval),
        .st_wmask  (st_wmask),
        .bus_rdata (bus_rdata)
    );

    for (genvar n = 0; n < NT; n++) begin : g_chan
        tmr_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we[n]),
            .cnt_we  (cnt_we[n]),
            .be      (bus_be),
            .wdata   (bus_wdata),
            .ctrl_o  (ctrl[n]),
            .cnt_o   (cnt[n]),
            .hit_o   (hit[n])
        );
    end

    tmr_irq_agg #(.NT(NT)) u_agg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .wdog_i   (wdog_warn),
        .en_wval  (en_wval),
        .en_wmask (en_wmask),
        .st_wval  (st_wval),
        .st_wmask (st_wmask),
        .en_o     (en_q),
        .st_o     (st_q),
        .irq_o    (irq_o)
    );
endmodule

// File: tb/multi_timer_irq_tb.sv
module multi_timer_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_word = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_warn = 1'b0;
    logic        irq_o;
    int          n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    multi_timer_irq #(.WIDE_LAYOUT(1'b0), .WORD_AW(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdog_warn(wdog_warn), .irq_o(irq_o)
    );

    // Compact layout word map (R1)
    localparam int W_IRQ = 0, W_CTRL = 1, W_CNT = 4;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Tasks start and end at a falling edge.
    task automatic wr(input int w, input logic [3:0] be, input logic [31:0] d);
        bus_wr = 1'b1; bus_word = 6'(w); bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input int w, output logic [31:0] d);
        bus_rd = 1'b1; bus_word = 6'(w);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic stop_all();
        for (int t = 0; t < 3; t++) wr(W_CTRL + t, 4'hF, 32'h0);
        for (int t = 0; t < 3; t++) wr(W_CNT + t, 4'hF, 32'h0);
        wr(W_IRQ, 4'b1100, 32'h0F00_0000);
    endtask

    function automatic logic [31:0] exp_count(input int k, input int c, input bit p);
        if (p) return 32'(k % (c + 1));
        return 32'((k < c) ? k : c);
    endfunction

    function automatic logic [31:0] ctrl_word(input bit run, input bit p, input int c);
        return {run, p, 30'(c)};
    endfunction

    logic [31:0] v, v0;

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R9 irq low after reset", 32'(irq_o), 32'h0);
        rd(W_IRQ, v);  check("R1 enable/pending reset", v, 32'h0);
        rd(W_CTRL, v); check("R2 control reset", v, 32'h0);
        rd(W_CNT, v);  check("R3 count reset", v, 32'h0);

        // Control readback
        wr(W_CTRL + 1, 4'hF, 32'h4000_0123);
        rd(W_CTRL + 1, v); check("R2 control readback", v, 32'h4000_0123);
        wr(W_CTRL + 1, 4'b0001, 32'hFFFF_FF77);
        rd(W_CTRL + 1, v); check("R1 byte lane write", v, 32'h4000_0177);
        wr(W_CTRL + 1, 4'hF, 32'h0);

        // Enable register in lane 2, no watchdog bit
        wr(W_IRQ, 4'b0100, 32'hFFFF_FFFF);
        rd(W_IRQ, v); check("R8 enable has no wdog bit", v, 32'h0007_0000);
        wr(W_IRQ, 4'b0100, 32'h0);

        // Count width and hold while stopped
        wr(W_CNT, 4'hF, 32'hFFFF_FFFF);
        rd(W_CNT, v); check("R3 count upper bits zero", v, 32'h3FFF_FFFF);
        idle(5);
        rd(W_CNT, v); check("R4 stopped count holds", v, 32'h3FFF_FFFF);
        wr(W_CNT, 4'hF, 32'h0);

        // Unmapped words
        wr(9, 4'hF, 32'hFFFF_FFFF);
        rd(9, v); check("R10 unmapped read zero", v, 32'h0);
        rd(7, v); check("R10 unmapped read zero", v, 32'h0);
        rd(W_CTRL + 2, v); check("R10 unmapped write harmless", v, 32'h0);

        // Random trials
        for (int it = 0; it < 60; it++) begin
            int t, c, k;
            bit p, m;
            t = int'($urandom % 3);
            c = 2 + int'($urandom % 11);
            k = int'($urandom % 30);
            p = 1'($urandom);
            m = 1'($urandom);
            stop_all();
            wr(W_IRQ, 4'b0100, 32'(m) << (16 + t));
            wr(W_CTRL + t, 4'hF, ctrl_word(1'b1, p, c));
            idle(k);
            check("R9 irq timing", 32'(irq_o), 32'((k >= c + 2) && m));
            rd(W_CNT + t, v);
            check(p ? "R5 periodic count" : "R6 one-shot count", v, exp_count(k, c, p));
            rd(W_IRQ, v);
            check("R5 pending set on match", v,
                  (32'(m) << (16 + t)) | (32'(k >= c) << (24 + t)));
            rd(W_CTRL + t, v);
            check("R6 run bit after match", v, ctrl_word(p || (k + 2 <= c), p, c));
        end
        stop_all();
        wr(W_IRQ, 4'b0100, 32'h0);

        // Write-zero and masked-lane writes leave pending bits alone
        wr(W_CTRL, 4'hF, ctrl_word(1'b1, 1'b0, 3));
        idle(10);
        wr(W_IRQ, 4'b1000, 32'h0);
        rd(W_IRQ, v); check("R7 write zero keeps bit", v, 32'h0100_0000);
        wr(W_IRQ, 4'b0100, 32'h0100_0000);
        rd(W_IRQ, v); check("R1 pending needs lane 3", v, 32'h0100_0000);
        wr(W_IRQ, 4'b1000, 32'h0100_0000);
        rd(W_IRQ, v); check("R7 write one clears", v, 32'h0);

        // Set beats clear: limit 0 periodic matches every clock
        wr(W_CTRL + 1, 4'hF, ctrl_word(1'b1, 1'b1, 0));
        idle(2);
        wr(W_IRQ, 4'b1000, 32'h0200_0000);
        rd(W_IRQ, v); check("R7 set wins over clear", v, 32'h0200_0000);
        stop_all();

        // Masking: expired timer is silent until enabled
        wr(W_CTRL + 2, 4'hF, ctrl_word(1'b1, 1'b0, 2));
        idle(8);
        check("R9 masked source silent", 32'(irq_o), 32'h0);
        wr(W_IRQ, 4'b0100, 32'h0004_0000);
        check("R9 irq one clock later", 32'(irq_o), 32'h0);
        idle(1);
        check("R9 unmasked source raises irq", 32'(irq_o), 32'h1);
        stop_all();
        wr(W_IRQ, 4'b0100, 32'h0);
        idle(1);
        check("R9 irq low after clear", 32'(irq_o), 32'h0);

        // Watchdog pending bit, unmaskable
        wdog_warn = 1'b1;
        @(negedge clk);
        wdog_warn = 1'b0;
        check("R9 wdog irq registered", 32'(irq_o), 32'h0);
        idle(1);
        check("R8 wdog raises irq unmasked", 32'(irq_o), 32'h1);
        rd(W_IRQ, v); check("R8 wdog pending at bit 3", v, 32'h0800_0000);
        wr(W_IRQ, 4'b1000, 32'h0800_0000);
        idle(1);
        check("R8 irq drops after wdog clear", 32'(irq_o), 32'h0);
        wdog_warn = 1'b1;
        wr(W_IRQ, 4'b1000, 32'h0800_0000);
        rd(W_IRQ, v); check("R7 wdog set wins", v, 32'h0800_0000);
        wdog_warn = 1'b0;
        wr(W_IRQ, 4'b1000, 32'h0800_0000);
        rd(W_IRQ, v); check("R7 wdog cleared", v, 32'h0);

        // Read data holds between reads
        wr(W_CTRL, 4'hF, 32'h4000_0055);
        rd(W_CTRL, v0);
        wr(W_CTRL, 4'hF, 32'h0);
        idle(3);
        check("R11 rdata holds", bus_rdata, v0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule